// File: doc/BRIEF.md
# Byte-Wide SPI Master Data Path with Collision Detection

This block is the data side of a simple SPI master on a small register bus. Software writes a byte to the data address. If the port is enabled and no shift is running, that byte is latched into a holding buffer and sent out MSB first on `mosi`. At the same time, `miso` is captured into a receive byte. Once the last bit has moved, a completion flag is set, and it can raise an interrupt request.

The serial clock idles low. The master changes `mosi` after each falling edge of `sclk` and samples `miso` on each rising edge. Each `sclk` level lasts `HALF_PERIOD` system clocks.

A write to the data address while a shift is pending or running does not disturb that shift. Instead, it sets a sticky collision flag. Both flags are cleared by a two-step sequence: first a status read that sees a flag set, then an access to the data address. The holding buffer and the received byte have no reset, so they keep their contents across reset.

Top module: `spi_host_port`

## Requirements
- R1: In the cycle after reset is released, the control and status registers read zero, `sclk` is low and `irq` is low.
- R2: A data write (address 2) while enabled and idle starts a transfer that sends the written byte MSB first on `mosi`. `sclk` idles low and each of its levels lasts `HALF_PERIOD` system clocks. Eight rising edges occur per transfer, and `mosi` changes only while `sclk` is low.
- R3: `miso` is sampled on each rising `sclk` edge, MSB first. After the transfer, a read of address 2 returns the assembled byte.
- R4: When the eighth bit completes, status bit 7 (transfer done) becomes 1.
- R5: A data write during a pending or running transfer sets status bit 6 (collision). The transfer in progress still sends its original byte, and the collision write starts no further transfer.
- R6: Both status flags are sticky. They clear only when a status read (address 1) that returns a set flag is followed by a read or write of address 2. A status read alone, or a data access without such a prior status read, leaves them set.
- R7: `irq` is high exactly when the done flag, control bit 1 (interrupt enable) and the `gie` input were all 1 on the previous clock.
- R8: With control bit 0 (enable) at 0, a data write starts no transfer and `sclk` stays low.
- R9: Reset leaves the data register unchanged: the byte last received still reads back from address 2 after reset.
- R10: Address 0 is control, with bit 0 enable and bit 1 interrupt enable. A read strobe updates `rdata` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| gie | input | 1 | Global interrupt enable from outside the block |
| irq | output | 1 | Registered interrupt request |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The transfers use random bytes for both `mosi` and `miso` with a fixed seed. This separates bit order, bit alignment and receive assembly, which patterns such as 0x00 or 0xFF would hide. The directed cases are:
- A collision write halfway through a shift, which shows whether the running byte is kept and whether a second shift is started.
- A data write while disabled.
- Flag-clearing sequences in both the valid order and the invalid order.
- A reset after a completed transfer, which shows whether the received byte survives.

Each transfer also draws random settings for the interrupt enable and `gie`, so the interrupt gating is tried in all of its combinations.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_IE_BIT = 1;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int WIDTH       = 8,
  parameter int HALF_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] tx_byte,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [WIDTH-1:0] rx_byte
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_PERIOD - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WIDTH - 1);

  logic [CW-1:0]    div_cnt;
  logic [BW-1:0]    bit_idx;
  logic [WIDTH-1:0] shreg;
  logic             tick, rise_now, fall_now, last_fall;

  assign tick      = busy && (div_cnt == DIV_LAST);
  assign rise_now  = tick && !sclk;
  assign fall_now  = tick && sclk;
  assign last_fall = fall_now && (bit_idx == BIT_LAST);

  // control and pins
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        sclk    <= 1'b0;
        mosi    <= tx_byte[WIDTH-1];
        div_cnt <= '0;
        bit_idx <= '0;
      end else if (busy) begin
        if (tick) begin
          div_cnt <= '0;
          sclk    <= ~sclk;
          if (last_fall) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (fall_now) begin
            bit_idx <= bit_idx + 1'b1;
            mosi    <= shreg[WIDTH-1];
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  // data path without reset: contents survive reset
  always_ff @(posedge clk) begin
    if (start)
      shreg <= tx_byte;
    else if (rise_now)
      shreg <= {shreg[WIDTH-2:0], miso};
    if (last_fall)
      rx_byte <= shreg;
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  p_mosi_steady_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             gie,
  output logic             irq,
  input  logic             busy,
  input  logic             done,
  input  logic [WIDTH-1:0] rx_byte,
  output logic             start,
  output logic [WIDTH-1:0] tx_hold
);
  logic ctrl_en, ctrl_ie, done_f, wcol_f, armed;
  logic busy_all, data_acc, data_wr, stat_rd, flag_clear;

  assign busy_all   = busy | start;
  assign data_acc   = (wr_en | rd_en) && (addr == ADDR_DATA);
  assign data_wr    = wr_en && (addr == ADDR_DATA);
  assign stat_rd    = rd_en && (addr == ADDR_STAT);
  assign flag_clear = data_acc && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      ctrl_ie <= 1'b0;
      done_f  <= 1'b0;
      wcol_f  <= 1'b0;
      armed   <= 1'b0;
      start   <= 1'b0;
      rdata   <= '0;
      irq     <= 1'b0;
    end else begin
      start <= data_wr && ctrl_en && !busy_all;
      if (wr_en && addr == ADDR_CTRL) begin
        ctrl_en <= wdata[CTRL_EN_BIT];
        ctrl_ie <= wdata[CTRL_IE_BIT];
      end
      done_f <= done | (done_f & ~flag_clear);
      wcol_f <= (data_wr & busy_all) | (wcol_f & ~flag_clear);
      if (stat_rd)
        armed <= done_f | wcol_f;
      else if (data_acc)
        armed <= 1'b0;
      if (rd_en) begin
        case (addr)
          ADDR_CTRL: rdata <= {{(WIDTH-2){1'b0}}, ctrl_ie, ctrl_en};
          ADDR_STAT: rdata <= {done_f, wcol_f, {(WIDTH-2){1'b0}}};
          ADDR_DATA: rdata <= rx_byte;
          default:   rdata <= '0;
        endcase
      end
      irq <= done_f & ctrl_ie & gie;
    end
  end

  // holding buffer, no reset
  always_ff @(posedge clk) begin
    if (data_wr && !busy_all)
      tx_hold <= wdata;
  end

  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  p_wcol_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (wcol_f && !data_acc) |=> wcol_f);
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_f));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (done_f && !data_acc) |=> done_f);
endmodule

// File: rtl/spi_host_port.sv
module spi_host_port #(
  parameter int DATA_W      = 8,
  parameter int HALF_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              gie,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic              start, busy, done;
  logic [DATA_W-1:0] tx_hold, rx_byte;

  spi_reg_bank #(.WIDTH(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .gie(gie), .irq(irq),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .start(start), .tx_hold(tx_hold)
  );

  spi_shift_engine #(.WIDTH(DATA_W), .HALF_PERIOD(HALF_PERIOD)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_hold), .miso(miso),
    .busy(busy), .sclk(sclk), .mosi(mosi), .done(done), .rx_byte(rx_byte)
  );
endmodule

// File: tb/test_spi_host_port.sv
module test_spi_host_port;
  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, gie = 1'b0, miso = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, sclk, mosi;

  int checks = 0;
  int errors = 0;

  spi_host_port #(.DATA_W(8), .HALF_PERIOD(HP)) i_spi_host_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .gie(gie), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_val(input logic d, input logic c);
    return {d, c, 6'b0};
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // transfer with a bench-side slave model; optional collision write
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rxp, input bit collide,
                      output logic [7:0] seen, output int rises, output int half);
    logic prev = 1'b0;
    int falls = 0;
    int cyc = 0;
    int rise_at = -1;
    bit wrote = 0;
    seen = 8'd0; rises = 0; half = -1;
    miso = rxp[7];
    bus_write(2'd2, tx);
    while (falls < 8 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (wr_en) wr_en = 1'b0;
      if (sclk && !prev) begin
        seen = {seen[6:0], mosi};
        rises++;
        if (rise_at < 0) rise_at = cyc;
      end
      if (!sclk && prev) begin
        if (half < 0) half = cyc - rise_at;
        falls++;
        if (falls < 8) miso = rxp[7 - falls];
        if (collide && falls == 3 && !wrote) begin
          addr = 2'd2; wdata = ~tx; wr_en = 1'b1; wrote = 1;
        end
      end
      prev = sclk;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic watch_idle(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, seen, tx, rxp;
    int rises, half, highs, seed;
    logic ie, g;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sclk", sclk, 0);
    chk("R1 irq", irq, 0);
    bus_read(2'd0, rd); chk("R1 ctrl", rd, 0);
    bus_read(2'd1, rd); chk("R1 status", rd, 0);

    // R8: disabled port ignores data writes
    bus_write(2'd2, 8'h5A);
    watch_idle(40, highs);
    chk("R8 no sclk while disabled", highs, 0);
    bus_read(2'd1, rd); chk("R8 no done while disabled", rd, 0);

    // random transfers with random interrupt gating
    for (int k = 0; k < 8; k++) begin
      tx = 8'($urandom()); rxp = 8'($urandom());
      ie = 1'($urandom()); g = 1'($urandom());
      if (k == 0) begin ie = 1; g = 1; tx = 8'h96; rxp = 8'h3C; end
      gie = g;
      bus_write(2'd0, {6'b0, ie, 1'b1});
      if (k == 0) begin
        bus_read(2'd0, rd); chk("R10 ctrl readback", rd, 8'h03);
      end
      xfer(tx, rxp, 0, seen, rises, half);
      chk("R2 mosi byte", seen, tx);
      chk("R2 rise count", rises, 8);
      chk("R2 half period", half, HP);
      chk("R7 irq gating", irq, ie & g);
      bus_read(2'd1, rd); chk("R4 done flag", rd, stat_val(1, 0));
      bus_read(2'd2, rd); chk("R3 received byte", rd, rxp);
      bus_read(2'd1, rd); chk("R6 cleared after sequence", rd, 0);
      chk("R7 irq drops with flag", irq, 0);
    end

    // R7: gie toggled live with a pending done flag
    gie = 0;
    bus_write(2'd0, 8'h03);
    xfer(8'hC3, 8'h81, 0, seen, rises, half);
    chk("R7 irq low with gie 0", irq, 0);
    @(negedge clk); gie = 1;
    @(negedge clk);
    chk("R7 irq follows gie", irq, 1);
    bus_write(2'd0, 8'h01);
    @(negedge clk);
    chk("R7 irq low with ie 0", irq, 0);

    // R6: wrong order leaves flags set
    bus_read(2'd2, rd); chk("R3 second byte", rd, 8'h81);
    bus_read(2'd1, rd); chk("R6 data access alone keeps flag", rd, stat_val(1, 0));
    bus_read(2'd1, rd); chk("R6 status read alone keeps flag", rd, stat_val(1, 0));
    bus_write(2'd2, 8'h00);  // clears and starts a transfer
    repeat (80) @(negedge clk);
    bus_read(2'd1, rd); chk("R6 write clears then new done", rd, stat_val(1, 0));
    bus_read(2'd2, rd); // clear

    // R5: collision mid transfer
    xfer(8'hA7, 8'h5E, 1, seen, rises, half);
    chk("R5 original byte kept", seen, 8'hA7);
    watch_idle(60, highs);
    chk("R5 no extra transfer", highs, 0);
    bus_read(2'd1, rd); chk("R5 collision flag", rd, stat_val(1, 1));
    bus_read(2'd2, rd); chk("R5 received byte", rd, 8'h5E);
    bus_read(2'd1, rd); chk("R6 both flags cleared", rd, 0);

    // R5: collision in the cycle right after the starting write
    bus_write(2'd2, 8'h11);
    bus_write(2'd2, 8'h22);
    repeat (90) @(negedge clk);
    bus_read(2'd1, rd); chk("R5 early collision", rd, stat_val(1, 1));
    bus_read(2'd2, rd);
    watch_idle(40, highs);
    chk("R5 early no extra transfer", highs, 0);

    // R9: received byte kept through reset
    xfer(8'h0F, 8'hE4, 0, seen, rises, half);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    bus_read(2'd1, rd); chk("R1 status after reset", rd, 0);
    bus_read(2'd0, rd); chk("R1 ctrl after reset", rd, 0);
    bus_read(2'd2, rd); chk("R9 data kept over reset", rd, 8'hE4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule